// File: doc/BRIEF.md
# Three-Phase Sine-Table PWM Duty Generator

This block turns a carrier-timer update strobe into three compare values for sinusoidal PWM. A single table pointer walks an internal sine ROM; phases B and C read the same ROM at one third and two thirds of the table length ahead of phase A, which gives 120° and 240° spacing. Each signed Q15 sample is multiplied by an amplitude given in timer counts, rounded, and centred on half the carrier period, so the result falls in the counter's unsigned range. The result is then clamped to the interval from zero to the full period.

The strobe is asserted once at every carrier underflow and once at every period match, so the table holds two samples per carrier cycle. The ROM length is twice the carrier-to-sine ratio (15 by default, an odd multiple of three). The output frequency is lowered by holding each table entry for several strobes. Raising the amplitude raises the output voltage. The carrier counter, its comparators and dead-band insertion sit outside this block.

Top module: `sine_pwm_duty`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, all three compare outputs and `duty_vld_o` are 0.
- R2: A strobe on `upd_i` sampled at a clock edge makes `duty_vld_o` high for exactly one cycle, two edges later, and the compare outputs change only together with that pulse.
- R3: The ROM has L = 2·MF entries (MF = 15 gives 30), and entry k holds floor(32767·sin(2πk/L) + 0.5) as a signed 16-bit Q15 value.
- R4: Phase B uses entry (k + L/3) mod L and phase C uses entry (k + 2L/3) mod L, where k is the entry used by phase A for the same strobe.
- R5: Each compare value is half + ((s·amp + 2^14) >>> 15), with s the table sample. `half_per_i` and `amp_i` are sampled at the strobe edge.
- R6: A compare value below 0 becomes 0, and a value above 2·half becomes 2·half.
- R7: After entry L−1 the pointer returns to entry 0.
- R8: With hold value H (0 treated as 1), the pointer advances by one entry after every H-th strobe. Strobes alone move the pointer, and clock cycles without a strobe leave it unchanged.
- R9: The first strobe after reset uses entry 0 for phase A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_i | input | 1 | Carrier update strobe (underflow or period match) |
| half_per_i | input | 15 | Half of the carrier period, in counts |
| amp_i | input | 16 | Peak amplitude in counts (modulation index × half period) |
| hold_i | input | 8 | Strobes per table entry; 0 acts as 1 |
| cmp_a_o | output | 16 | Compare value for phase A |
| cmp_b_o | output | 16 | Compare value for phase B |
| cmp_c_o | output | 16 | Compare value for phase C |
| duty_vld_o | output | 1 | One-cycle pulse when new compare values appear |

## Verification
The bench covers several corner cases:
- Wrap from the last table entry to the first. A wrong wrap would skip an entry or read past the end.
- Offset phases crossing the end of the table. A missing modulo would give phases B and C stale or out-of-range samples.
- Negative samples at the rounding boundary. Truncation in place of rounding moves them one count.
- Amplitudes large enough to cross both clamps. A missing clamp would wrap the compare value around the counter range.
- Hold values of 0, 1 and 3. A counter that is off by one would change the sine period.
- Strobes on back-to-back cycles and strobes with gaps between them. Either pattern would expose a pointer that moves without a strobe or an output that changes without `duty_vld_o`.

// File: rtl/sine_pwm_pkg.sv
package sine_pwm_pkg;

  localparam int NUM_PH = 3;

  // Q15 sine sample for entry k of a len-entry table, rounded half up
  function automatic int q15_sine(input int k, input int len, input int smp_w);
    real ang;
    real amp;
    ang = 2.0 * 3.14159265358979 * real'(k) / real'(len);
    amp = real'((1 << (smp_w - 1)) - 1);
    return $rtoi($floor(amp * $sin(ang) + 0.5));
  endfunction

endpackage

// File: rtl/sine_rom.sv
module sine_rom
  import sine_pwm_pkg::*;
#(
  parameter int LEN   = 30,
  parameter int SMP_W = 16,
  parameter int AW    = $clog2(LEN)
) (
  input  logic                                 clk,
  input  logic                                 rd_en,
  input  logic [NUM_PH-1:0][AW-1:0]            rd_addr,
  output logic signed [NUM_PH-1:0][SMP_W-1:0]  rd_data
);

  logic signed [SMP_W-1:0] rom [LEN];

  initial begin
    for (int k = 0; k < LEN; k++) rom[k] = SMP_W'(q15_sine(k, LEN, SMP_W));
  end

  for (genvar p = 0; p < NUM_PH; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (rd_en) rd_data[p] <= rom[rd_addr[p]];
    end
  end

endmodule

// File: rtl/table_ptr.sv
module table_ptr
  import sine_pwm_pkg::*;
#(
  parameter int LEN   = 30,
  parameter int AW    = $clog2(LEN),
  parameter int DIV_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       step_i,
  input  logic [DIV_W-1:0]           hold_i,
  output logic [NUM_PH-1:0][AW-1:0]  idx_o
);

  logic [AW-1:0]    base_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W:0]   lim;
  logic [DIV_W:0]   cnt_nx;

  assign lim    = (hold_i == '0) ? (DIV_W+1)'(1) : {1'b0, hold_i};
  assign cnt_nx = {1'b0, cnt_q} + (DIV_W+1)'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (step_i) begin
      if (cnt_nx >= lim) begin
        cnt_q  <= '0;
        base_q <= (base_q == AW'(LEN - 1)) ? '0 : base_q + AW'(1);
      end else begin
        cnt_q <= cnt_nx[DIV_W-1:0];
      end
    end
  end

  for (genvar p = 0; p < NUM_PH; p++) begin : g_off
    localparam int OFF = (p * LEN) / NUM_PH;
    logic [AW:0] sum;
    assign sum      = {1'b0, base_q} + (AW+1)'(OFF);
    assign idx_o[p] = (sum >= (AW+1)'(LEN)) ? AW'(sum - (AW+1)'(LEN)) : sum[AW-1:0];
  end

  p_ptr_range_r7: assert property (@(posedge clk) disable iff (rst)
    base_q < AW'(LEN));
  p_ptr_still_r8: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(base_q));

endmodule

// File: rtl/duty_scale.sv
module duty_scale #(
  parameter int SMP_W = 16,
  parameter int CMP_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en_i,
  input  logic signed [SMP_W-1:0] smp_i,
  input  logic [CMP_W-1:0]        amp_i,
  input  logic [CMP_W-2:0]        half_i,
  output logic [CMP_W-1:0]        cmp_o
);

  localparam int PW = SMP_W + CMP_W + 2;

  logic signed [PW-1:0] smp_x, amp_x, prod, rnd, half_x, per_x, sum;

  always_comb begin
    smp_x  = PW'(smp_i);
    amp_x  = PW'({1'b0, amp_i});
    prod   = smp_x * amp_x;
    rnd    = (prod + PW'(1 << (SMP_W - 2))) >>> (SMP_W - 1);
    half_x = PW'({1'b0, half_i});
    per_x  = half_x <<< 1;
    sum    = half_x + rnd;
  end

  always_ff @(posedge clk) begin
    if (rst) cmp_o <= '0;
    else if (en_i) begin
      if (sum < 0)          cmp_o <= '0;
      else if (sum > per_x) cmp_o <= CMP_W'(per_x);
      else                  cmp_o <= CMP_W'(sum);
    end
  end

  p_cmp_bounded_r6: assert property (@(posedge clk) disable iff (rst)
    en_i |=> ({1'b0, cmp_o} <= {$past(half_i), 2'b00} >> 1));

endmodule

// File: rtl/sine_pwm_duty.sv
module sine_pwm_duty
  import sine_pwm_pkg::*;
#(
  parameter int MF    = 15,
  parameter int SMP_W = 16,
  parameter int CMP_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_i,
  input  logic [CMP_W-2:0] half_per_i,
  input  logic [CMP_W-1:0] amp_i,
  input  logic [DIV_W-1:0] hold_i,
  output logic [CMP_W-1:0] cmp_a_o,
  output logic [CMP_W-1:0] cmp_b_o,
  output logic [CMP_W-1:0] cmp_c_o,
  output logic             duty_vld_o
);

  localparam int LEN = 2 * MF;
  localparam int AW  = $clog2(LEN);

  logic [NUM_PH-1:0][AW-1:0]           idx;
  logic signed [NUM_PH-1:0][SMP_W-1:0] smp;
  logic [NUM_PH-1:0][CMP_W-1:0]        cmp;
  logic                                s1_vld;
  logic [CMP_W-1:0]                    amp_q;
  logic [CMP_W-2:0]                    half_q;

  table_ptr #(.LEN(LEN), .AW(AW), .DIV_W(DIV_W)) u_ptr (
    .clk(clk), .rst(rst), .step_i(upd_i), .hold_i(hold_i), .idx_o(idx)
  );

  sine_rom #(.LEN(LEN), .SMP_W(SMP_W), .AW(AW)) u_rom (
    .clk(clk), .rd_en(upd_i), .rd_addr(idx), .rd_data(smp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld     <= 1'b0;
      duty_vld_o <= 1'b0;
      amp_q      <= '0;
      half_q     <= '0;
    end else begin
      s1_vld     <= upd_i;
      duty_vld_o <= s1_vld;
      if (upd_i) begin
        amp_q  <= amp_i;
        half_q <= half_per_i;
      end
    end
  end

  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    duty_scale #(.SMP_W(SMP_W), .CMP_W(CMP_W)) u_scale (
      .clk(clk), .rst(rst), .en_i(s1_vld), .smp_i(smp[p]),
      .amp_i(amp_q), .half_i(half_q), .cmp_o(cmp[p])
    );
  end

  assign cmp_a_o = cmp[0];
  assign cmp_b_o = cmp[1];
  assign cmp_c_o = cmp[2];

  p_stage_r2: assert property (@(posedge clk) disable iff (rst)
    upd_i |=> s1_vld);
  p_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    s1_vld |=> duty_vld_o);
  p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !s1_vld |=> ($stable(cmp_a_o) && $stable(cmp_b_o) && $stable(cmp_c_o)));
  p_zero_amp_r5: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && amp_q == '0) |=> (cmp_a_o == {1'b0, $past(half_q)}));

endmodule

// File: tb/sine_pwm_duty_tb_top.sv
module sine_pwm_duty_tb_top;

  localparam int MF = 15;
  localparam int L  = 2 * MF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd = 1'b0;
  logic [14:0] half = '0;
  logic [15:0] amp = '0;
  logic [7:0]  hold = 8'd1;
  logic [15:0] cmp_a, cmp_b, cmp_c;
  logic        vld;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sine_pwm_duty dut_i (
    .clk(clk), .rst(rst), .upd_i(upd), .half_per_i(half), .amp_i(amp),
    .hold_i(hold), .cmp_a_o(cmp_a), .cmp_b_o(cmp_b), .cmp_c_o(cmp_c),
    .duty_vld_o(vld)
  );

  // reference table, rounded half up (R3)
  int tbl [L];
  initial begin
    for (int k = 0; k < L; k++)
      tbl[k] = $rtoi($floor(32767.0 * $sin(2.0 * 3.14159265358979 * k / L) + 0.5));
  end

  function automatic int ref_cmp(int s, int a, int h);
    longint p, r, v;
    p = longint'(s) * longint'(a);
    r = (p + 64'sd16384) >>> 15;
    v = longint'(h) + r;
    if (v < 0) v = 0;
    if (v > 2 * h) v = 2 * h;
    return int'(v);
  endfunction

  // behavioural reference model
  int m_idx, m_cnt, m_sa, m_sb, m_sc, m_amp, m_half;
  bit m_s1;
  int e_a, e_b, e_c;
  bit e_v;
  always @(posedge clk) begin
    int lim;
    if (rst) begin
      m_idx = 0; m_cnt = 0; m_s1 = 0; e_v = 0; e_a = 0; e_b = 0; e_c = 0;
    end else begin
      e_v = m_s1;
      if (m_s1) begin
        e_a = ref_cmp(m_sa, m_amp, m_half);
        e_b = ref_cmp(m_sb, m_amp, m_half);
        e_c = ref_cmp(m_sc, m_amp, m_half);
      end
      m_s1 = upd;
      if (upd) begin
        m_sa = tbl[m_idx];
        m_sb = tbl[(m_idx + L / 3) % L];
        m_sc = tbl[(m_idx + 2 * L / 3) % L];
        m_amp = amp; m_half = half;
        lim = (hold == 0) ? 1 : hold;
        m_cnt++;
        if (m_cnt >= lim) begin
          m_cnt = 0;
          m_idx = (m_idx + 1) % L;
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model, away from the edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 vld", int'(vld), int'(e_v));
      chk("R5 cmp_a", int'(cmp_a), e_a);
      chk("R4 cmp_b", int'(cmp_b), e_b);
      chk("R4 cmp_c", int'(cmp_c), e_c);
    end
  end

  task automatic strobe(int gap);
    @(negedge clk); upd = 1'b1;
    @(negedge clk); upd = 1'b0;
    for (int i = 0; i < gap; i++) @(negedge clk);
  endtask

  initial begin
    #5000000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 a", int'(cmp_a), 0); chk("R1 b", int'(cmp_b), 0);
    chk("R1 c", int'(cmp_c), 0); chk("R1 vld", int'(vld), 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 after", int'(cmp_a) + int'(vld), 0);

    // R9/R3/R4: unity gain exposes raw samples
    half = 15'd32767; amp = 16'd32768; hold = 8'd1;
    strobe(2);
    chk("R9 first entry", int'(cmp_a), 32767 + tbl[0]);
    chk("R3 R4 entry B", int'(cmp_b), 32767 + tbl[L / 3]);
    chk("R4 entry C", int'(cmp_c), 32767 + tbl[2 * L / 3]);

    // R7: full sweep and wrap, back-to-back strobes
    @(negedge clk); upd = 1'b1;
    repeat (2 * L + 3) @(negedge clk);
    upd = 1'b0;
    repeat (3) @(negedge clk);

    // R5: nominal amplitude, gapped strobes
    half = 15'd13333; amp = 16'd10667;
    for (int i = 0; i < 40; i++) strobe(i % 4);

    // R5: zero amplitude sits at half
    amp = 16'd0;
    strobe(2);
    chk("R5 zero amp", int'(cmp_a), 13333);

    // R6: saturation both ways
    half = 15'd100; amp = 16'd65535;
    for (int i = 0; i < L; i++) strobe(1);

    // R8: hold 3 then hold 0
    half = 15'd5000; amp = 16'd4000; hold = 8'd3;
    for (int i = 0; i < 50; i++) strobe(i % 3);
    hold = 8'd0;
    for (int i = 0; i < 20; i++) strobe(0);

    // R8: no strobes for a while, pointer must not move
    repeat (25) @(negedge clk);
    hold = 8'd1;
    for (int i = 0; i < 5; i++) strobe(1);

    // R2: inputs change between strobes without effect
    half = 15'd777; amp = 16'd99;
    repeat (10) @(negedge clk);
    chk("R2 hold outputs", int'(vld), 0);
    repeat (3) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule